// File: doc/BRIEF.md
# H-Bridge Three-Level Gate Sequencer

This block drives the four switches of one H-bridge at the fundamental frequency, so that the bridge output goes through a zero step, a positive step, a second zero step and a negative step in each period. A counter runs over the period length given on the `period` input, in clock cycles. Leg A follows a 50 % square wave taken from that count. Leg B follows the same square wave delayed by a quarter of the period. Inside each leg the high-side and low-side switches always get opposite drive.

Both redundant zero states are used. In the first quarter of the period both high-side switches are on. In the third quarter both low-side switches are on. A small signed code on `level` reports the bridge output for each cycle. When the block is disabled it parks the bridge with both low-side switches on, and it starts again at count zero when enabled.

Top module: `hb3_gate_seq`

## Requirements
- R1: While enabled, with effective period N and count c, `gate_ah` is 1 for c < floor(N/2) and 0 otherwise.
- R2: While enabled, `gate_bl` is 1 for floor(N/4) <= c < floor(N/4)+floor(N/2) and 0 otherwise. `gate_bl` is the low-side switch of leg B, and its wave lags `gate_ah` by a quarter period.
- R3: In every cycle `gate_al` is the inverse of `gate_ah` and `gate_bh` is the inverse of `gate_bl`, so no leg ever has both switches on.
- R4: `level` is 2'b01 (+1) when `gate_ah` and `gate_bl` are on. It is 2'b11 (-1) when `gate_bh` and `gate_al` are on. It is 2'b00 (0) otherwise. It is valid in the same cycle as the gates.
- R5: In any cycle after a clock edge where `rst` was high or `en` was low, the outputs are `gate_al`=1, `gate_bl`=1, `gate_ah`=0, `gate_bh`=0 and `level`=0.
- R6: The first clock edge with `en` high after an idle or reset cycle produces the outputs for count 0. Each following enabled edge advances the count by one.
- R7: A `period` value below 4 is treated as 4.
- R8: `period` is read in every cycle. The count returns to 0 on the edge after a cycle where count+1 >= N. If `period` is lowered below the current count, the count wraps on the next edge, and the outputs for that out-of-range count follow R1 and R2 with the new N.

Parameter: `CNT_W` (default 16) sets the width of the counter and of the `period` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the bridge and clears the count |
| period | input | CNT_W | Fundamental period in clock cycles |
| gate_ah | output | 1 | Leg A high-side switch drive |
| gate_al | output | 1 | Leg A low-side switch drive |
| gate_bh | output | 1 | Leg B high-side switch drive |
| gate_bl | output | 1 | Leg B low-side switch drive (quarter-period lagging wave) |
| level | output | 2 | Bridge output code: 01 = +1, 00 = 0, 11 = -1 |

## Verification
Two kinds of event can fall on the same edge. The first is a period wrap together with a drop of `en`. The second is a wrap together with a change of `period`, including a drop of `period` below the running count, which forces an early wrap. The bench provokes both by changing `en` or `period` exactly in the cycle whose count is N-1 or above. It judges the result against a behavioural model that runs on every clock. That model must show the idle state or count 0 on the next cycle, and the out-of-range count must decode to the gate pattern set by the new N.

// File: rtl/hb3_pkg.sv
`timescale 1ns/1ps
package hb3_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'b00,
    LVL_POS  = 2'b01,
    LVL_NEG  = 2'b11
  } lvl_t;

  // a_hi: leg A high side on; b_lo: leg B low side on
  function automatic lvl_t lvl_decode(input logic a_hi, input logic b_lo);
    if (a_hi && b_lo)        return LVL_POS;
    else if (!a_hi && !b_lo) return LVL_NEG;
    else                     return LVL_ZERO;
  endfunction
endpackage

// File: rtl/hb3_period_timer.sv
`timescale 1ns/1ps
module hb3_period_timer #(
  parameter int CNT_W   = 16,
  parameter int MIN_PER = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_eff
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  always_comb per_eff = (period < MIN_P) ? MIN_P : period;

  always_ff @(posedge clk) begin
    if (rst || !en)                 cnt <= '0;
    else if (cnt >= per_eff - ONE)  cnt <= '0;
    else                            cnt <= cnt + ONE;
  end

  // R8: a count at or past the last slot returns to zero
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (en && (cnt >= per_eff - ONE)) |=> (cnt == '0));

  // R6: an idle cycle leaves the count at zero for the restart
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (cnt == '0));
endmodule

// File: rtl/hb3_phase_gen.sv
`timescale 1ns/1ps
module hb3_phase_gen #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per_eff,
  output logic             wave_a,
  output logic             wave_b
);
  logic [CNT_W-1:0] half_p;
  logic [CNT_W-1:0] quart_p;
  logic [CNT_W:0]   end_b;

  always_comb begin
    half_p  = per_eff >> 1;
    quart_p = per_eff >> 2;
    end_b   = {1'b0, quart_p} + {1'b0, half_p};
    wave_a  = (cnt < half_p);
    wave_b  = (cnt >= quart_p) && ({1'b0, cnt} < end_b);
  end
endmodule

// File: rtl/hb3_leg_drive.sv
`timescale 1ns/1ps
module hb3_leg_drive (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hi_req,
  output logic hi_on,
  output logic lo_on
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hi_on <= 1'b0;
      lo_on <= 1'b1;
    end else begin
      hi_on <= hi_req;
      lo_on <= !hi_req;
    end
  end

  // R3: the two switches of one leg are never on together or off together
  assert_leg_comp_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hi_on != lo_on));
endmodule

// File: rtl/hb3_gate_seq.sv
`timescale 1ns/1ps
module hb3_gate_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic             gate_ah,
  output logic             gate_al,
  output logic             gate_bh,
  output logic             gate_bl,
  output logic [1:0]       level
);
  import hb3_pkg::*;

  localparam int NLEG = 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_eff;
  logic             wave_a;
  logic             wave_b;
  logic [NLEG-1:0]  hi_req;
  logic [NLEG-1:0]  hi_on;
  logic [NLEG-1:0]  lo_on;
  lvl_t             lvl_q;

  hb3_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .en(en), .period(period),
    .cnt(cnt), .per_eff(per_eff)
  );

  hb3_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .cnt(cnt), .per_eff(per_eff), .wave_a(wave_a), .wave_b(wave_b)
  );

  // leg A high side follows wave_a; leg B low side follows the lagging wave
  always_comb hi_req = {!wave_b, wave_a};

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb3_leg_drive u_leg (
      .clk(clk), .rst(rst), .run(en), .hi_req(hi_req[g]),
      .hi_on(hi_on[g]), .lo_on(lo_on[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) lvl_q <= LVL_ZERO;
    else            lvl_q <= lvl_decode(wave_a, wave_b);
  end

  always_comb begin
    gate_ah = hi_on[0];
    gate_al = lo_on[0];
    gate_bh = hi_on[1];
    gate_bl = lo_on[1];
    level   = lvl_q;
  end

  // R5: parked state after an idle cycle
  assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (!gate_ah && gate_al && !gate_bh && gate_bl && level == 2'b00));

  // R4: the level code agrees with the switch pattern
  assert_lvl_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (level == 2'b01) |-> (gate_ah && gate_bl));
  assert_lvl_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (level == 2'b11) |-> (gate_bh && gate_al));
  assert_lvl_code_R4: assert property (@(posedge clk) disable iff (rst)
    (level != 2'b10));
endmodule

// File: tb/tb_hb3_gate_seq.sv
`timescale 1ns/1ps
module tb_hb3_gate_seq;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [CNT_W-1:0] period = 16'd8;
  logic gate_ah, gate_al, gate_bh, gate_bl;
  logic [1:0] level;

  int total = 0;
  int bad   = 0;
  bit chk_on = 0;

  always #2.5 clk = ~clk;

  hb3_gate_seq #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .en(en), .period(period),
    .gate_ah(gate_ah), .gate_al(gate_al), .gate_bh(gate_bh),
    .gate_bl(gate_bl), .level(level)
  );

  // behavioural reference: position in the period as a plain integer
  int   idx = 0;
  bit   was_idle = 1;
  logic e_ah = 0, e_bl = 1;
  logic [1:0] e_lvl = 2'b00;
  string ctx = "R5";

  always @(posedge clk) begin
    if (rst || !en) begin
      idx = 0; was_idle = 1;
      e_ah = 0; e_bl = 1; e_lvl = 2'b00; ctx = "R5";
    end else begin
      int n, h, q;
      n = (int'(period) < 4) ? 4 : int'(period);
      h = n / 2; q = n / 4;
      e_ah = (idx < h);
      e_bl = (idx >= q) && (idx < q + h);
      e_lvl = (e_ah && e_bl) ? 2'b01 : (!e_ah && !e_bl) ? 2'b11 : 2'b00;
      if (was_idle)             ctx = "R6";
      else if (idx >= n)        ctx = "R8";
      else if (int'(period) < 4) ctx = "R7";
      else                      ctx = "";
      was_idle = 0;
      idx = (idx + 1 >= n) ? 0 : idx + 1;
    end
  end

  task automatic check1(input string rq, input string what,
                        input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      string r1, r2, r3, r4;
      r1 = (ctx == "") ? "R1" : ctx;
      r2 = (ctx == "") ? "R2" : ctx;
      r3 = (ctx == "") ? "R3" : ctx;
      r4 = (ctx == "") ? "R4" : ctx;
      check1(r1, "gate_ah", {1'b0, gate_ah}, {1'b0, e_ah});
      check1(r2, "gate_bl", {1'b0, gate_bl}, {1'b0, e_bl});
      check1(r3, "gate_al", {1'b0, gate_al}, {1'b0, !e_ah});
      check1(r3, "gate_bh", {1'b0, gate_bh}, {1'b0, !e_bl});
      check1(r4, "level",   level, e_lvl);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk_on = 1;             // reset state checked (R5)
    cyc(2);
    rst = 0;
    cyc(3);                 // idle with en low (R5)
    period = 16'd8; en = 1; // restart at count 0 (R6)
    cyc(20);
    en = 0; cyc(3); en = 1; // drop mid period, restart (R6)
    cyc(13);
    period = 16'd12; cyc(30);
    period = 16'd10; cyc(25); // N not a multiple of 4 (R1, R2)
    // drop en exactly in the last slot of a period (wrap + disable)
    en = 0; cyc(1); en = 1; period = 16'd8; cyc(7);
    en = 0; cyc(2); en = 1; cyc(11);
    period = 16'd2; cyc(12);  // below minimum (R7)
    period = 16'd0; cyc(6);   // R7
    period = 16'd12; en = 0; cyc(1); en = 1; cyc(10);
    period = 16'd6; cyc(14);  // lowered below running count (R8)
    period = 16'd16; cyc(8);
    period = 16'd5; cyc(12);  // change to odd length mid run (R8)
    rst = 1; cyc(2); rst = 0; cyc(20); // reset while running (R5, R6)
    period = 16'd4; cyc(12);
    chk_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule